// File: doc/BRIEF.md
# Dual-Rail Strong-Indication Majority Voter

This block settles a three-way redundant result. Each of three replicas delivers one dual-rail encoded bit (pairs P, Q and R). The block forms a 2-of-3 vote on the true rails and a separate 2-of-3 vote on the false rails. It also watches the three pairs with a completion detector. The voted rails reach the output pair (M1, M0) only through a pair of Muller C-elements that also wait on the completion signal. The output therefore leaves spacer only after every pair carries data, and it returns to spacer only after every pair has returned to spacer. Two agreeing replicas can never get ahead of a late third one.

A parameter selects return-to-zero or return-to-one signalling. In return-to-one mode the rail votes take the OR-AND form and the per-pair completion terms become ANDs. The C-elements keep their set/hold rule in both modes. Each C-element is a state register clocked by a fast sampling clock, and a synchronous reset loads it with the spacer level of the chosen protocol. If any pair shows the illegal code, an error flag is raised and every stateful element holds its value.

Top module: `dr_majority_voter`

## Requirements
- R1: After synchronous active-low reset, both output rails sit at the spacer level of the selected protocol (0 for return-to-zero, 1 for return-to-one), and `err_o` is 0.
- R2: Codes are written as (rail1, rail0). In return-to-zero, spacer is (0,0), data one is (1,0) and data zero is (0,1). In return-to-one, spacer is (1,1), data one is (0,1) and data zero is (1,0). Both protocols use these codes on the inputs and on the output.
- R3: When all three pairs carry data, the output shows the majority value at the second rising clock edge after the last pair arrives, and not at the first.
- R4: While one or two pairs carry data and the rest are spacer, the output stays spacer, even when the two data pairs agree.
- R5: The output returns to spacer at the second rising edge after the last pair returns to spacer.
- R6: While only some pairs have returned to spacer, the output keeps its previous data value.
- R7: The output never shows the illegal code (both rails active).
- R8: A pair with the illegal code (both rails 1 in return-to-zero, both rails 0 in return-to-one) sets `err_o` at the next rising edge. While any pair is illegal, the output and the completion state do not change. `err_o` clears one edge after the code is gone.
- R9: In return-to-one mode, the block behaves as the exact rail complement of return-to-zero mode under the complemented stimulus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock for the C-element state |
| rst_n | input | 1 | Synchronous active-low reset |
| p1_i | input | 1 | Replica P, true rail |
| p0_i | input | 1 | Replica P, false rail |
| q1_i | input | 1 | Replica Q, true rail |
| q0_i | input | 1 | Replica Q, false rail |
| r1_i | input | 1 | Replica R, true rail |
| r0_i | input | 1 | Replica R, false rail |
| m1_o | output | 1 | Voted output, true rail |
| m0_o | output | 1 | Voted output, false rail |
| err_o | output | 1 | Registered illegal-code flag |

## Verification
The bench builds two copies of the block side by side: one with the protocol parameter set to return-to-zero and one set to return-to-one. The return-to-one copy is fed the bitwise complement of every stimulus. A single walk through the vector sequence therefore covers the AND-OR and OR-AND vote variants and both completion-detector forms. It also checks both reset levels, and it tests the complement relation of R9 at every step. Late arrival, partial return and illegal-code holds are exercised in both modes with the same expected values.

// File: rtl/dr_vote_pkg.sv
// Package: shared protocol type and helpers for the dual-rail voter.
// Assumes: one dual-rail pair per replica, codes written (rail1, rail0).
package dr_vote_pkg;

    typedef enum logic {
        PROTO_RTZ = 1'b0,
        PROTO_RTO = 1'b1
    } vote_proto_e;

    // Level that every rail takes while a pair is in spacer.
    function automatic logic spacer_level(input vote_proto_e p);
        return (p == PROTO_RTO) ? 1'b1 : 1'b0;
    endfunction

endpackage

// File: rtl/dr_celem.sv
// Module: N-input Muller C-element kept as a clocked state bit.
// It sets when all inputs are 1, clears when all are 0, and otherwise holds.
// The hold_i input freezes the state whatever the inputs are.
// Assumes: inputs are sampled on clk faster than any handshake phase.
module dr_celem #(
    parameter int N       = 2,
    parameter bit RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold_i,
    input  logic [N-1:0] in_i,
    output logic         out_o
);

    logic all_hi;
    logic all_lo;

    // Agreement decode of the inputs.
    always_comb begin
        all_hi = &in_i;
        all_lo = ~|in_i;
    end

    // State update following the set/hold rule.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_o <= RST_VAL;
        end else if (!hold_i) begin
            if (all_hi) begin
                out_o <= 1'b1;
            end else if (all_lo) begin
                out_o <= 1'b0;
            end
        end
    end

    // R3: unanimous high inputs set the state.
    assert_set_on_agree_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_i && (&in_i)) |=> out_o);

    // R5: unanimous low inputs clear the state.
    assert_clear_on_agree_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_i && (~|in_i)) |=> !out_o);

    // R4 / R6: mixed inputs or a hold leave the state alone.
    assert_hold_on_mixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i || (!(&in_i) && (|in_i))) |=> $stable(out_o));

endmodule

// File: rtl/dr_vote_rail.sv
// Module: 2-of-3 vote on one rail, written as a single complex term.
// Return-to-zero uses the AND-OR form and return-to-one uses the dual OR-AND form.
// Assumes: the three inputs are the same rail taken from the three replicas.
module dr_vote_rail
    import dr_vote_pkg::*;
#(
    parameter vote_proto_e PROTO = PROTO_RTZ
) (
    input  logic a_i,
    input  logic b_i,
    input  logic c_i,
    output logic y_o
);

    generate
        if (PROTO == PROTO_RTZ) begin : g_and_or
            // Sum of pairwise products.
            always_comb y_o = (a_i & b_i) | (b_i & c_i) | (a_i & c_i);
        end else begin : g_or_and
            // Product of pairwise sums.
            always_comb y_o = (a_i | b_i) & (b_i | c_i) & (a_i | c_i);
        end
    endgenerate

endmodule

// File: rtl/dr_arrival_detect.sv
// Module: internal completion detector over NPAIR dual-rail pairs.
// It reduces each pair to a "present" bit and joins those bits in one C-element.
// It also flags any pair that shows the illegal code.
// Assumes: the caller forwards illegal_o to hold_i so that a bad code freezes the state.
module dr_arrival_detect
    import dr_vote_pkg::*;
#(
    parameter vote_proto_e PROTO = PROTO_RTZ,
    parameter int          NPAIR = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_i,
    input  logic [NPAIR-1:0] rail1_i,
    input  logic [NPAIR-1:0] rail0_i,
    output logic             done_o,
    output logic             illegal_o
);

    localparam bit RST_LVL = spacer_level(PROTO);

    logic [NPAIR-1:0] present;
    logic [NPAIR-1:0] bad;

    genvar gi;
    generate
        for (gi = 0; gi < NPAIR; gi++) begin : g_pair
            if (PROTO == PROTO_RTZ) begin : g_rtz
                // Any active rail marks data; both active is illegal.
                always_comb begin
                    present[gi] = rail1_i[gi] | rail0_i[gi];
                    bad[gi]     = rail1_i[gi] & rail0_i[gi];
                end
            end else begin : g_rto
                // A low rail marks data; both low is illegal.
                always_comb begin
                    present[gi] = rail1_i[gi] & rail0_i[gi];
                    bad[gi]     = ~(rail1_i[gi] | rail0_i[gi]);
                end
            end
        end
    endgenerate

    // Illegal code on any pair.
    always_comb illegal_o = |bad;

    dr_celem #(.N(NPAIR), .RST_VAL(RST_LVL)) u_join (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold_i (hold_i),
        .in_i   (present),
        .out_o  (done_o)
    );

    // R4: completion moves only after every pair agrees.
    assert_done_needs_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o != $past(done_o)) |-> $past((&present) || (~|present)));

endmodule

// File: rtl/dr_majority_voter.sv
// Module: strong-indication 3-input majority voter on dual-rail pairs.
// Per-rail 2-of-3 votes are joined with an internal completion signal through
// C-elements, so the output waits for all three pairs in both handshake phases.
// Assumes: inputs obey the 4-phase order of the chosen protocol; an illegal
// pair is flagged and freezes the state.
module dr_majority_voter
    import dr_vote_pkg::*;
#(
    parameter vote_proto_e PROTO = PROTO_RTZ
) (
    input  logic clk,
    input  logic rst_n,
    input  logic p1_i,
    input  logic p0_i,
    input  logic q1_i,
    input  logic q0_i,
    input  logic r1_i,
    input  logic r0_i,
    output logic m1_o,
    output logic m0_o,
    output logic err_o
);

    localparam bit SP = spacer_level(PROTO);
    localparam int NREP = 3;

    logic nm1;
    logic nm0;
    logic ncd;
    logic illegal;
    logic out_act;
    logic ncd_act;

    dr_vote_rail #(.PROTO(PROTO)) u_vote_t (
        .a_i(p1_i), .b_i(q1_i), .c_i(r1_i), .y_o(nm1)
    );

    dr_vote_rail #(.PROTO(PROTO)) u_vote_f (
        .a_i(p0_i), .b_i(q0_i), .c_i(r0_i), .y_o(nm0)
    );

    dr_arrival_detect #(.PROTO(PROTO), .NPAIR(NREP)) u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_i    (illegal),
        .rail1_i   ({r1_i, q1_i, p1_i}),
        .rail0_i   ({r0_i, q0_i, p0_i}),
        .done_o    (ncd),
        .illegal_o (illegal)
    );

    dr_celem #(.N(2), .RST_VAL(SP)) u_join_t (
        .clk(clk), .rst_n(rst_n), .hold_i(illegal),
        .in_i({nm1, ncd}), .out_o(m1_o)
    );

    dr_celem #(.N(2), .RST_VAL(SP)) u_join_f (
        .clk(clk), .rst_n(rst_n), .hold_i(illegal),
        .in_i({nm0, ncd}), .out_o(m0_o)
    );

    // Registered error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_o <= 1'b0;
        end else begin
            err_o <= illegal;
        end
    end

    // Protocol-neutral activity views, used only by the assertions below.
    always_comb begin
        out_act = (m1_o != SP) || (m0_o != SP);
        ncd_act = (ncd != SP);
    end

    // R7: the output never carries both rails active.
    assert_no_double_rail_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !((m1_o != SP) && (m0_o != SP)));

    // R8: an illegal pair freezes the output and raises the flag.
    assert_illegal_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> (err_o && $stable(m1_o) && $stable(m0_o)));

    // R3: output data appears only once completion has been seen.
    assert_data_after_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_act) |-> $past(ncd_act));

    // R5: output spacer appears only once completion has dropped.
    assert_spacer_after_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_act) |-> !$past(ncd_act));

endmodule

// File: tb/tb_dr_majority_voter.sv
module tb_dr_majority_voter;
    import dr_vote_pkg::*;

    localparam logic [1:0] SPC = 2'b00;
    localparam logic [1:0] ONE = 2'b10;
    localparam logic [1:0] ZER = 2'b01;
    localparam logic [1:0] BAD = 2'b11;
    localparam int NVEC = 17;

    // {p, q, r, expected m, requirement code}; codes 0:R3 1:R4 2:R5 3:R6 (RTZ view)
    localparam logic [9:0] VEC [NVEC] = '{
        {SPC, SPC, SPC, SPC, 2'd2},   // R5 idle
        {ONE, SPC, SPC, SPC, 2'd1},   // R4 one arrival
        {ONE, ONE, SPC, SPC, 2'd1},   // R4 two agree, third late
        {ONE, ONE, ZER, ONE, 2'd0},   // R3 majority one
        {SPC, ONE, ZER, ONE, 2'd3},   // R6 partial return
        {SPC, SPC, ZER, ONE, 2'd3},   // R6 partial return
        {SPC, SPC, SPC, SPC, 2'd2},   // R5 full return
        {ZER, ZER, ONE, ZER, 2'd0},   // R3 majority zero
        {SPC, SPC, SPC, SPC, 2'd2},   // R5
        {ONE, ZER, ONE, ONE, 2'd0},   // R3 split, ones win
        {SPC, SPC, SPC, SPC, 2'd2},   // R5
        {ZER, ONE, ZER, ZER, 2'd0},   // R3 split, zeros win
        {SPC, SPC, SPC, SPC, 2'd2},   // R5
        {ZER, ZER, ZER, ZER, 2'd0},   // R3 unanimous zero
        {SPC, SPC, SPC, SPC, 2'd2},   // R5
        {ONE, ONE, ONE, ONE, 2'd0},   // R3 unanimous one
        {SPC, SPC, SPC, SPC, 2'd2}    // R5
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] p = SPC, q = SPC, r = SPC;
    logic m1_z, m0_z, err_z;
    logic m1_o, m0_o, err_oo;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dr_majority_voter #(.PROTO(PROTO_RTZ)) dut (
        .clk(clk), .rst_n(rst_n),
        .p1_i(p[1]), .p0_i(p[0]), .q1_i(q[1]), .q0_i(q[0]), .r1_i(r[1]), .r0_i(r[0]),
        .m1_o(m1_z), .m0_o(m0_z), .err_o(err_z)
    );

    // R9: return-to-one copy sees the complemented stimulus.
    dr_majority_voter #(.PROTO(PROTO_RTO)) dut_rto (
        .clk(clk), .rst_n(rst_n),
        .p1_i(~p[1]), .p0_i(~p[0]), .q1_i(~q[1]), .q0_i(~q[0]), .r1_i(~r[1]), .r0_i(~r[0]),
        .m1_o(m1_o), .m0_o(m0_o), .err_o(err_oo)
    );

    function automatic string req_name(input logic [1:0] k);
        case (k)
            2'd0: return "R3";
            2'd1: return "R4";
            2'd2: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Compare both copies against the expected RTZ output; R7 and R9 ride along.
    task automatic chk_both(input string tag, input logic [1:0] exp_m, input logic exp_err);
        chk({tag, " rtz"}, {m1_z, m0_z}, exp_m);
        chk({tag, " R9 rto"}, {m1_o, m0_o}, ~exp_m);
        chk({tag, " err rtz"}, {1'b0, err_z}, {1'b0, exp_err});
        chk({tag, " err R9 rto"}, {1'b0, err_oo}, {1'b0, exp_err});
        chk({tag, " R7 exclusive"}, {1'b0, m1_z & m0_z}, 2'b00);
    endtask

    task automatic drive(input logic [1:0] np, input logic [1:0] nq, input logic [1:0] nr);
        @(negedge clk);
        p = np; q = nq; r = nr;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state in both protocols.
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 rtz reset", {m1_z, m0_z}, 2'b00);
        chk("R1 rto reset", {m1_o, m0_o}, 2'b11);
        chk("R1 err reset", {err_z, err_oo}, 2'b00);
        rst_n = 1'b1;
        edges(1);

        // R2/R3/R4/R5/R6: table walk.
        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][9:8], VEC[i][7:6], VEC[i][5:4]);
            edges(3);
            chk_both($sformatf("%s step %0d", req_name(VEC[i][1:0]), i), VEC[i][3:2], 1'b0);
        end

        // R3: exact latency after the last arrival.
        drive(ONE, ZER, SPC);
        edges(3);
        drive(ONE, ZER, ZER);
        edges(1);
        chk_both("R3 not after first edge", SPC, 1'b0);
        edges(1);
        chk_both("R3 at second edge", ZER, 1'b0);

        // R5: exact latency after the last return.
        drive(SPC, SPC, ZER);
        edges(3);
        chk_both("R6 hold before last return", ZER, 1'b0);
        drive(SPC, SPC, SPC);
        edges(1);
        chk_both("R5 not after first edge", ZER, 1'b0);
        edges(1);
        chk_both("R5 at second edge", SPC, 1'b0);

        // R8: an illegal pair from spacer must not let data through.
        drive(BAD, ONE, ONE);
        edges(1);
        chk_both("R8 flag from spacer", SPC, 1'b1);
        edges(3);
        chk_both("R8 output held at spacer", SPC, 1'b1);
        drive(SPC, SPC, SPC);
        edges(1);
        chk_both("R8 flag clears", SPC, 1'b0);
        edges(3);
        chk_both("R8 no leftover state", SPC, 1'b0);

        // R8: an illegal pair during data must not move the output.
        drive(ONE, ONE, ONE);
        edges(3);
        chk_both("R3 data before illegal", ONE, 1'b0);
        drive(BAD, SPC, SPC);
        edges(4);
        chk_both("R8 output held at data", ONE, 1'b1);
        drive(SPC, SPC, SPC);
        edges(3);
        chk_both("R5 return after illegal cleared", SPC, 1'b0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule